// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block lays a 64 by 64 pixel cursor over a stream of display pixels. The cursor image is held in video memory as 2-bit codes. Each code picks one of two cursor colours, lets the display pixel show through, or inverts that pixel. For every incoming pixel, the block works out whether the pixel falls inside the cursor window. If it does, the block reads the bitmap byte that covers the pixel, decodes the 2-bit lane for that pixel, and emits the merged pixel one clock later.

The cursor is placed on screen by its top-left coordinate. Its bitmap base is given in 8-byte units. A 6-bit vertical clip value shortens the drawn image from the bottom: the number of rows drawn is 64 minus the clip value, and the rows that remain are still read from the top of the bitmap. A single enable bit turns the overlay on and off. Memory arbitration and horizontal clipping belong to the surrounding logic.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0 and `memRd` stays 0 until a pixel arrives.
- R2: `outValid` equals `pixValid` delayed by exactly one clock. `outPix` belongs to the pixel accepted one clock earlier.
- R3: A pixel whose column lies outside `cursorX` to `cursorX+63` is emitted unchanged.
- R4: For a pixel inside the window, `memRd` is asserted in that pixel's own cycle. `memAddr` is `cursorBase*8 + row*16 + col/4`, where row = `pixY-cursorY` and col = `pixX-cursorX`. The memory returns `memData` on the following clock.
- R5: Within a bitmap byte, the pixel at col mod 4 = k uses bits 2k+1:2k. Bits 1:0 are used first.
- R6: Code 0 outputs `colour0` and code 1 outputs `colour1`. In both cases the low 8 bits of the output are forced to 0xFF.
- R7: Code 2 outputs the display pixel unchanged. Code 3 outputs the bitwise complement of the display pixel.
- R8: Only rows 0 to 63-`cursorVOff` are drawn. A pixel at row 64-`cursorVOff` or below passes unchanged and issues no read. With `cursorVOff` = 0, all 64 rows are drawn.
- R9: With `cursorEn` = 0, no memory read is issued and every pixel passes unchanged.
- R10: A pixel above `cursorY`, or at row 64 or below, passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Display pixel present this cycle |
| pixData | input | PIX_W | Display pixel value |
| pixX | input | COORD_W | Column of the display pixel |
| pixY | input | COORD_W | Line of the display pixel |
| cursorX | input | COORD_W | Left column of the cursor |
| cursorY | input | COORD_W | Top line of the cursor |
| cursorBase | input | ADDR_W-3 | Bitmap base in 8-byte units |
| cursorVOff | input | 6 | Vertical clip, rows removed from the bottom |
| cursorEn | input | 1 | Overlay enable |
| colour0 | input | PIX_W | Colour for code 0 |
| colour1 | input | PIX_W | Colour for code 1 |
| memRd | output | 1 | Bitmap read request |
| memAddr | output | ADDR_W | Bitmap byte address |
| memData | input | 8 | Bitmap byte, one clock after the request |
| outValid | output | 1 | Merged pixel present |
| outPix | output | PIX_W | Merged pixel |

## Verification
A wrong window or clip decision shows up at `memRd` and `memAddr` in the same cycle as the pixel. It shows up again at `outPix` one clock later, as a cursor pixel where a plain pixel was expected, or the reverse. A wrong lane carried in the strobe struct, or a decode fault, shows up only in that delayed `outPix`, and only for codes that the bitmap actually contains. The bench therefore walks whole rows, including the columns just past both window edges, so that every lane and every code is seen. A pipeline valid fault shows as `outValid` out of step with `pixValid` on the very next clock.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
  // strobes passed from the fetch control to the merge datapath
  typedef struct packed {
    logic       load;  // a display pixel is accepted this cycle
    logic       hit;   // the pixel lies inside the drawn cursor area
    logic [1:0] lane;  // 2-bit lane inside the fetched byte
  } curStrobe_t;
endpackage

// File: rtl/cursor_fetch_ctrl.sv
module cursor_fetch_ctrl
  import cursor_overlay_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int ADDR_W   = 16,
  parameter int CUR_SIZE = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixValid,
  input  logic [COORD_W-1:0]  pixX,
  input  logic [COORD_W-1:0]  pixY,
  input  logic [COORD_W-1:0]  cursorX,
  input  logic [COORD_W-1:0]  cursorY,
  input  logic [ADDR_W-4:0]   cursorBase,
  input  logic [$clog2(CUR_SIZE)-1:0] cursorVOff,
  input  logic                cursorEn,
  output logic                memRd,
  output logic [ADDR_W-1:0]   memAddr,
  output curStrobe_t          strobe
);
  localparam int COL_W         = $clog2(CUR_SIZE);
  localparam int BYTES_PER_ROW = CUR_SIZE / 4;
  localparam int BITMAP_BYTES  = CUR_SIZE * BYTES_PER_ROW;

  logic [COORD_W-1:0] dx, dy;
  logic [COL_W:0]     rowLimit;
  logic               inX, inY, hit;
  logic [ADDR_W-1:0]  baseAddr;

  always_comb begin
    dx       = pixX - cursorX;
    dy       = pixY - cursorY;
    rowLimit = (COL_W+1)'(CUR_SIZE) - {1'b0, cursorVOff};
    inX      = (pixX >= cursorX) && (dx < COORD_W'(CUR_SIZE));
    inY      = (pixY >= cursorY) && (dy < COORD_W'(rowLimit));
    hit      = cursorEn && pixValid && inX && inY;
    baseAddr = {cursorBase, 3'b000};
  end

  assign memRd   = hit;
  // row*BYTES_PER_ROW + col/4 is a plain concatenation for power-of-two rows
  assign memAddr = baseAddr + ADDR_W'({dy[COL_W-1:0], dx[COL_W-1:2]});

  assign strobe.load = pixValid;
  assign strobe.hit  = hit;
  assign strobe.lane = dx[1:0];

  AST_ADDR_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> memAddr >= baseAddr); // R4
  AST_ADDR_IN_BITMAP: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr - baseAddr) < ADDR_W'(BITMAP_BYTES)); // R4
endmodule

// File: rtl/cursor_merge_dp.sv
module cursor_merge_dp
  import cursor_overlay_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  curStrobe_t       strobe,
  input  logic [PIX_W-1:0] pixData,
  input  logic [7:0]       memData,
  input  logic [PIX_W-1:0] colour0,
  input  logic [PIX_W-1:0] colour1,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);
  localparam logic [PIX_W-1:0] LOW_FILL = PIX_W'(8'hFF);

  curStrobe_t       strbQ;
  logic [PIX_W-1:0] pixQ;
  logic [1:0]       code;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbQ <= '0;
      pixQ  <= '0;
    end else begin
      strbQ <= strobe;
      pixQ  <= pixData;
    end
  end

  always_comb begin
    code = 2'(memData >> {strbQ.lane, 1'b0});
    outPix = pixQ;
    if (strbQ.hit) begin
      unique case (code)
        2'd0: outPix = colour0 | LOW_FILL;
        2'd1: outPix = colour1 | LOW_FILL;
        2'd2: outPix = pixQ;
        2'd3: outPix = ~pixQ;
      endcase
    end
  end

  assign outValid = strbQ.load;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid); // R2
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter int PIX_W    = 32,
  parameter int COORD_W  = 12,
  parameter int ADDR_W   = 16,
  parameter int CUR_SIZE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixData,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [COORD_W-1:0] cursorX,
  input  logic [COORD_W-1:0] cursorY,
  input  logic [ADDR_W-4:0]  cursorBase,
  input  logic [5:0]         cursorVOff,
  input  logic               cursorEn,
  input  logic [PIX_W-1:0]   colour0,
  input  logic [PIX_W-1:0]   colour1,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPix
);
  localparam int VOFF_W = $clog2(CUR_SIZE);

  curStrobe_t strobe;

  cursor_fetch_ctrl #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .CUR_SIZE(CUR_SIZE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .cursorX(cursorX), .cursorY(cursorY), .cursorBase(cursorBase),
    .cursorVOff(VOFF_W'(cursorVOff)), .cursorEn(cursorEn),
    .memRd(memRd), .memAddr(memAddr), .strobe(strobe)
  );

  cursor_merge_dp #(.PIX_W(PIX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixData(pixData),
    .memData(memData), .colour0(colour0), .colour1(colour1),
    .outValid(outValid), .outPix(outPix)
  );

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !cursorEn) |=> (outPix == $past(pixData))); // R9
  AST_NO_READ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cursorEn |-> !memRd); // R9
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  localparam int PIX_W = 32, COORD_W = 12, ADDR_W = 16;

  logic clk = 0, rstN = 0;
  logic pixValid = 0;
  logic [PIX_W-1:0] pixData = '0;
  logic [COORD_W-1:0] pixX = '0, pixY = '0;
  logic [COORD_W-1:0] cursorX = 12'd100, cursorY = 12'd50;
  logic [ADDR_W-4:0] cursorBase = 13'h123;
  logic [5:0] cursorVOff = 6'd0;
  logic cursorEn = 1;
  logic [PIX_W-1:0] colour0 = 32'h11223344, colour1 = 32'hA5B6C7D8;
  logic memRd;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData = '0;
  logic outValid;
  logic [PIX_W-1:0] outPix;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cursor_overlay u0 (.*);

  function automatic logic [7:0] patByte(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = a * 16'd29 + (a >> 4) * 16'd7;
    return t[7:0] ^ 8'h96;
  endfunction

  always @(posedge clk) if (memRd) memData <= patByte(memAddr);

  function automatic logic inCursor(input logic [COORD_W-1:0] x, y);
    int dx, dy;
    dx = int'(x) - int'(cursorX);
    dy = int'(y) - int'(cursorY);
    return cursorEn && dx >= 0 && dx < 64 && dy >= 0 && dy < 64 - int'(cursorVOff);
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr(input logic [COORD_W-1:0] x, y);
    int dx, dy;
    dx = int'(x) - int'(cursorX);
    dy = int'(y) - int'(cursorY);
    return ADDR_W'(int'(cursorBase) * 8 + dy * 16 + dx / 4);
  endfunction

  function automatic logic [PIX_W-1:0] expPix(input logic [COORD_W-1:0] x, y,
                                              input logic [PIX_W-1:0] d);
    logic [7:0] b;
    int k;
    logic [1:0] c;
    if (!inCursor(x, y)) return d;
    b = patByte(expAddr(x, y));
    k = (int'(x) - int'(cursorX)) % 4;
    c = 2'((b >> (2 * k)) & 8'h3);
    case (c)
      2'd0: return colour0 | 32'hFF;
      2'd1: return colour1 | 32'hFF;
      2'd2: return d;
      default: return ~d;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one pixel: drive at negedge, check the read request, check the output a clock later
  task automatic sendPix(input logic [COORD_W-1:0] x, y, input string req);
    logic [PIX_W-1:0] d;
    logic hitExp;
    d = {x, y, 8'h3C} ^ 32'h5A0F_C3E1;
    pixX = x; pixY = y; pixData = d; pixValid = 1;
    hitExp = inCursor(x, y);
    #1;
    check(req, 64'(memRd), 64'(hitExp), "memRd");
    if (hitExp) check("R4", 64'(memAddr), 64'(expAddr(x, y)), "memAddr");
    @(posedge clk); @(negedge clk);
    check("R2", 64'(outValid), 64'd1, "outValid");
    check(req, 64'(outPix), 64'(expPix(x, y, d)), "outPix");
  endtask

  task automatic idleCheck();
    pixValid = 0;
    @(posedge clk); @(negedge clk);
    check("R2", 64'(outValid), 64'd0, "outValid idle");
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", 64'(outValid), 64'd0, "outValid in reset");
    rstN = 1;
    @(posedge clk); @(negedge clk);
    check("R1", 64'(outValid), 64'd0, "outValid after reset");
    check("R1", 64'(memRd), 64'd0, "memRd after reset");
  endtask

  task automatic testRowScan();
    // crosses both horizontal edges: covers all lanes and codes (R3 R5 R6 R7)
    for (int i = -3; i < 68; i++) sendPix(COORD_W'(int'(cursorX) + i), cursorY + 12'd3, "R5");
    idleCheck();
  endtask

  task automatic testRows();
    int rows[4] = '{0, 17, 31, 63};
    foreach (rows[r])
      for (int i = 0; i < 8; i++) sendPix(cursorX + COORD_W'(i * 7), cursorY + COORD_W'(rows[r]), "R6");
    sendPix(cursorX - 12'd1, cursorY, "R3");
    sendPix(cursorX + 12'd64, cursorY, "R3");
    idleCheck();
  endtask

  task automatic testVerticalClip();
    cursorVOff = 6'd10;
    sendPix(cursorX + 12'd5, cursorY + 12'd53, "R8");
    sendPix(cursorX + 12'd5, cursorY + 12'd54, "R8");
    sendPix(cursorX + 12'd6, cursorY + 12'd60, "R8");
    cursorVOff = 6'd63;
    sendPix(cursorX + 12'd2, cursorY, "R8");
    sendPix(cursorX + 12'd2, cursorY + 12'd1, "R8");
    cursorVOff = 6'd0;
    sendPix(cursorX + 12'd9, cursorY + 12'd63, "R8");
    sendPix(cursorX + 12'd9, cursorY + 12'd64, "R10");
    sendPix(cursorX + 12'd9, cursorY - 12'd1, "R10");
    idleCheck();
  endtask

  task automatic testDisabled();
    cursorEn = 0;
    for (int i = 0; i < 16; i++) sendPix(cursorX + COORD_W'(i * 4), cursorY + 12'd2, "R9");
    cursorEn = 1;
    idleCheck();
  endtask

  task automatic testMoved();
    cursorX = 12'd7; cursorY = 12'd0; cursorBase = 13'h040;
    colour0 = 32'hDEADBE00; colour1 = 32'h0F0F0F0F;
    for (int i = 0; i < 64; i++) sendPix(COORD_W'(7 + i), 12'd20, "R7");
    idleCheck();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testRowScan();
    testRows();
    testVerticalClip();
    testDisabled();
    testMoved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule